// File: doc/BRIEF.md
# Vectored Interrupt Controller with Fast-Interrupt Class

The controller collects level-sensitive interrupt requests from a set of peripheral channels and sorts each one into one of two classes. The fast class is meant for the lowest-latency path to the processor. All enabled fast-class requests are ORed onto a single fast-interrupt output. A status word tells software which fast channels are asking for service.

Every other channel is a vectored normal interrupt with its own 4-bit priority. The normal-interrupt output is the OR of all enabled normal requests. A registered arbiter picks one winner each cycle, and the vector-address register returns the address programmed for that winner, so the service routine can branch to it directly.

Configuration goes through a single-cycle synchronous register bus. The bus has a word index, a combinational read path and writes that take effect at the clock edge.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, `fiq_o` and `irq_o` are low, every channel is disabled and in the normal class, and every priority, channel vector and the default vector read as zero.
- R2: Requests are synchronized through two flops. A level change on `irq_req_i` that is captured at one rising edge is visible on the outputs and in the status words after exactly two edges. Index 0x00 reads the synchronized raw requests.
- R3: A channel is pending only when its request is high and it is enabled. Writing to index 0x03 sets the enable bits where `wdata` is 1, and a read of 0x03 returns the enable mask. Writing to index 0x04 clears the enable bits where `wdata` is 1. A cleared channel drops out of both output ORs from the edge that performs the write.
- R4: Index 0x05 holds the class mask, where bit n = 1 puts channel n in the fast class. `fiq_o` is the OR of all pending fast-class channels, and index 0x01 reads the mask of pending fast-class channels.
- R5: `irq_o` is the OR of all pending normal-class channels, and index 0x02 reads the mask of pending normal-class channels.
- R6: Index 0x40+n holds the priority of channel n in bits [3:0], where 0 is the most urgent. Among pending normal channels, the smallest priority value wins. On equal values, the lowest channel number wins.
- R7: Index 0x06 reads the vector held at index 0x80+n for the registered winner n. The winner is registered one edge after the pending set settles. When no normal channel is pending, the read returns the default vector at index 0x07.
- R8: A write of any value to index 0x06 marks end of service. It changes no output and no readable state, and the outputs keep following the live requests.
- R9: A fast-class channel never takes part in vector arbitration, whatever its priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req_i | input | NUM_CH | Level-sensitive request per channel |
| bus_en_i | input | 1 | Register access strobe |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 8 | Register word index |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Combinational read data |
| fiq_o | output | 1 | Fast-interrupt output |
| irq_o | output | 1 | Normal-interrupt output |

## Verification
The bench builds the block with its defaults: 32 channels, 4-bit priorities and a 32-bit data path. All 32 channels therefore fill the enable, class and status words, and the arbiter runs the full channel range. Random priorities are often limited to the range 0..3, which makes ties between channels frequent. The directed cases then target tie-breaking, fast-class exclusion from arbitration, the default vector and the exact two-edge synchronizer latency.

// File: rtl/vic_pkg.sv
package vic_pkg;

    localparam int MAX_CH_IDX_W = 6;

    localparam logic [7:0] IDX_RAW      = 8'h00;
    localparam logic [7:0] IDX_FST      = 8'h01;
    localparam logic [7:0] IDX_NST      = 8'h02;
    localparam logic [7:0] IDX_EN_SET   = 8'h03;
    localparam logic [7:0] IDX_EN_CLR   = 8'h04;
    localparam logic [7:0] IDX_CLASS    = 8'h05;
    localparam logic [7:0] IDX_VECT     = 8'h06;
    localparam logic [7:0] IDX_DEFAULT  = 8'h07;
    localparam logic [1:0] PRIO_PAGE    = 2'b01;
    localparam logic [1:0] VECT_PAGE    = 2'b10;

    typedef enum logic [3:0] {
        K_NONE, K_RAW, K_FST, K_NST, K_EN_SET, K_EN_CLR,
        K_CLASS, K_VECT, K_DEFAULT, K_PRIO, K_CHVEC
    } reg_kind_e;

    typedef struct packed {
        logic                    hit;
        logic [MAX_CH_IDX_W-1:0] ch;
    } win_t;

    function automatic reg_kind_e decode_idx(input logic [7:0] a);
        reg_kind_e k;
        k = K_NONE;
        if (a[7:6] == PRIO_PAGE)      k = K_PRIO;
        else if (a[7:6] == VECT_PAGE) k = K_CHVEC;
        else begin
            case (a)
                IDX_RAW:     k = K_RAW;
                IDX_FST:     k = K_FST;
                IDX_NST:     k = K_NST;
                IDX_EN_SET:  k = K_EN_SET;
                IDX_EN_CLR:  k = K_EN_CLR;
                IDX_CLASS:   k = K_CLASS;
                IDX_VECT:    k = K_VECT;
                IDX_DEFAULT: k = K_DEFAULT;
                default:     k = K_NONE;
            endcase
        end
        return k;
    endfunction

endpackage

// File: rtl/vic_sync.sv
module vic_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [STAGES-1:0][W-1:0] stg_q;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stg_q[s] <= '0;
                    else     stg_q[s] <= d_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stg_q[s] <= '0;
                    else     stg_q[s] <= stg_q[s-1];
                end
            end
        end
    endgenerate

    assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/vic_regs.sv
module vic_regs
    import vic_pkg::*;
#(
    parameter int NUM_CH = 32,
    parameter int PRIO_W = 4,
    parameter int DATA_W = 32
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           bus_en_i,
    input  logic                           bus_wr_i,
    input  logic [7:0]                     bus_addr_i,
    input  logic [DATA_W-1:0]              bus_wdata_i,
    output logic [DATA_W-1:0]              bus_rdata_o,
    input  logic [NUM_CH-1:0]              raw_i,
    input  logic [NUM_CH-1:0]              fst_i,
    input  logic [NUM_CH-1:0]              nst_i,
    input  logic [DATA_W-1:0]              vect_rd_i,
    output logic [NUM_CH-1:0]              en_o,
    output logic [NUM_CH-1:0]              cls_o,
    output logic [NUM_CH-1:0][PRIO_W-1:0]  prio_o,
    output logic [NUM_CH-1:0][DATA_W-1:0]  chvec_o,
    output logic [DATA_W-1:0]              dflt_o
);
    localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    reg_kind_e         kind;
    logic              ch_ok;
    logic [CH_W-1:0]   ch_idx;
    logic              wr_stb;

    assign kind   = decode_idx(bus_addr_i);
    assign ch_ok  = (32'(bus_addr_i[5:0]) < NUM_CH);
    assign ch_idx = bus_addr_i[CH_W-1:0];
    assign wr_stb = bus_en_i && bus_wr_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_o    <= '0;
            cls_o   <= '0;
            prio_o  <= '0;
            chvec_o <= '0;
            dflt_o  <= '0;
        end else if (wr_stb) begin
            case (kind)
                K_EN_SET:  en_o   <= en_o | bus_wdata_i[NUM_CH-1:0];
                K_EN_CLR:  en_o   <= en_o & ~bus_wdata_i[NUM_CH-1:0];
                K_CLASS:   cls_o  <= bus_wdata_i[NUM_CH-1:0];
                K_DEFAULT: dflt_o <= bus_wdata_i;
                K_PRIO:    if (ch_ok) prio_o[ch_idx]  <= bus_wdata_i[PRIO_W-1:0];
                K_CHVEC:   if (ch_ok) chvec_o[ch_idx] <= bus_wdata_i;
                default:   ; // end-of-service and unmapped writes change nothing
            endcase
        end
    end

    always_comb begin
        bus_rdata_o = '0;
        case (kind)
            K_RAW:     bus_rdata_o = DATA_W'(raw_i);
            K_FST:     bus_rdata_o = DATA_W'(fst_i);
            K_NST:     bus_rdata_o = DATA_W'(nst_i);
            K_EN_SET:  bus_rdata_o = DATA_W'(en_o);
            K_CLASS:   bus_rdata_o = DATA_W'(cls_o);
            K_VECT:    bus_rdata_o = vect_rd_i;
            K_DEFAULT: bus_rdata_o = dflt_o;
            K_PRIO:    if (ch_ok) bus_rdata_o = DATA_W'(prio_o[ch_idx]);
            K_CHVEC:   if (ch_ok) bus_rdata_o = chvec_o[ch_idx];
            default:   bus_rdata_o = '0;
        endcase
    end

    AST_EN_SET: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && kind == K_EN_SET) |=> ((en_o & $past(bus_wdata_i[NUM_CH-1:0])) == $past(bus_wdata_i[NUM_CH-1:0]))); // R3
    AST_EN_CLR: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && kind == K_EN_CLR) |=> ((en_o & $past(bus_wdata_i[NUM_CH-1:0])) == '0)); // R3
    AST_EOS_NO_EFFECT: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && kind == K_VECT) |=> ($stable(en_o) && $stable(cls_o) && $stable(dflt_o))); // R8
endmodule

// File: rtl/vic_arbiter.sv
module vic_arbiter
    import vic_pkg::*;
#(
    parameter int NUM_CH = 32,
    parameter int PRIO_W = 4
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [NUM_CH-1:0]             pend_i,
    input  logic [NUM_CH-1:0][PRIO_W-1:0] prio_i,
    output win_t                          win_o
);
    win_t              win_d;
    logic [PRIO_W-1:0] best;

    always_comb begin
        win_d = '0;
        best  = '1;
        for (int i = 0; i < NUM_CH; i++) begin
            // strict compare keeps the lower channel on equal priority
            if (pend_i[i] && (!win_d.hit || prio_i[i] < best)) begin
                win_d.hit = 1'b1;
                win_d.ch  = MAX_CH_IDX_W'(i);
                best      = prio_i[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) win_o <= '0;
        else     win_o <= win_d;
    end

    AST_WIN_FOLLOWS_PEND: assert property (@(posedge clk) disable iff (rst)
        (|pend_i) |=> win_o.hit); // R7
    AST_NO_PEND_NO_WIN: assert property (@(posedge clk) disable iff (rst)
        !(|pend_i) |=> !win_o.hit); // R7
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
    import vic_pkg::*;
#(
    parameter int NUM_CH      = 32,
    parameter int PRIO_W      = 4,
    parameter int DATA_W      = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] irq_req_i,
    input  logic              bus_en_i,
    input  logic              bus_wr_i,
    input  logic [7:0]        bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              fiq_o,
    output logic              irq_o
);
    localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    logic [NUM_CH-1:0]              raw;
    logic [NUM_CH-1:0]              en;
    logic [NUM_CH-1:0]              cls;
    logic [NUM_CH-1:0][PRIO_W-1:0]  prio;
    logic [NUM_CH-1:0][DATA_W-1:0]  chvec;
    logic [DATA_W-1:0]              dflt;
    logic [NUM_CH-1:0]              pend;
    logic [NUM_CH-1:0]              fst;
    logic [NUM_CH-1:0]              nst;
    logic [DATA_W-1:0]              vect_rd;
    win_t                           win;

    vic_sync #(.W(NUM_CH), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .d_i(irq_req_i), .q_o(raw)
    );

    assign pend = raw & en;
    assign fst  = pend & cls;
    assign nst  = pend & ~cls;

    vic_arbiter #(.NUM_CH(NUM_CH), .PRIO_W(PRIO_W)) u_arb (
        .clk(clk), .rst(rst), .pend_i(nst), .prio_i(prio), .win_o(win)
    );

    assign vect_rd = win.hit ? chvec[win.ch[CH_W-1:0]] : dflt;

    vic_regs #(.NUM_CH(NUM_CH), .PRIO_W(PRIO_W), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst(rst),
        .bus_en_i(bus_en_i), .bus_wr_i(bus_wr_i), .bus_addr_i(bus_addr_i),
        .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o),
        .raw_i(raw), .fst_i(fst), .nst_i(nst), .vect_rd_i(vect_rd),
        .en_o(en), .cls_o(cls), .prio_o(prio), .chvec_o(chvec), .dflt_o(dflt)
    );

    assign fiq_o = |fst;
    assign irq_o = |nst;

    AST_CLR_ALL_QUIET: assert property (@(posedge clk) disable iff (rst)
        (bus_en_i && bus_wr_i && bus_addr_i == IDX_EN_CLR && (&bus_wdata_i[NUM_CH-1:0])) |=> (!fiq_o && !irq_o)); // R3
    AST_IRQ_WINNER: assert property (@(posedge clk) disable iff (rst)
        irq_o |=> win.hit); // R7
    AST_WIN_NOT_FAST: assert property (@(posedge clk) disable iff (rst)
        (win.hit && $stable(cls)) |-> !cls[win.ch[CH_W-1:0]]); // R9
    AST_DEFAULT_VEC: assert property (@(posedge clk) disable iff (rst)
        !win.hit |-> (vect_rd == dflt)); // R7
endmodule

// File: tb/tb_irq_vector_ctrl.sv
module tb_irq_vector_ctrl;
    localparam int NCH = 32;
    localparam int DW  = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NCH-1:0] req = '0;
    logic          ben = 1'b0;
    logic          bwr = 1'b0;
    logic [7:0]    badr = '0;
    logic [DW-1:0] bwd = '0;
    logic [DW-1:0] brd;
    logic          fiq, irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [NCH-1:0] m_en, m_cls;
    logic [3:0]     m_prio [NCH];
    logic [DW-1:0]  m_vec  [NCH];
    logic [DW-1:0]  m_dflt;

    always #4 clk = ~clk;

    irq_vector_ctrl dut (
        .clk(clk), .rst(rst), .irq_req_i(req), .bus_en_i(ben), .bus_wr_i(bwr),
        .bus_addr_i(badr), .bus_wdata_i(bwd), .bus_rdata_o(brd),
        .fiq_o(fiq), .irq_o(irq)
    );

    task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        ben = 1'b1; bwr = 1'b1; badr = a; bwd = d;
        @(negedge clk);
        ben = 1'b0; bwr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [DW-1:0] d);
        @(negedge clk);
        ben = 1'b1; bwr = 1'b0; badr = a;
        #1 d = brd;
        ben = 1'b0;
    endtask

    task automatic settle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    function automatic logic [DW-1:0] exp_vec(input logic [NCH-1:0] r);
        logic [NCH-1:0] p;
        int w;
        p = r & m_en & ~m_cls;
        w = -1;
        for (int i = 0; i < NCH; i++)
            if (p[i] && (w < 0 || m_prio[i] < m_prio[w])) w = i;
        return (w < 0) ? m_dflt : m_vec[w];
    endfunction

    task automatic set_prio(input int ch, input logic [3:0] p);
        m_prio[ch] = p;
        wr(8'h40 + 8'(ch), DW'(p));
    endtask

    task automatic full_check(input string tag);
        logic [DW-1:0] d;
        logic [NCH-1:0] f, n;
        f = req & m_en & m_cls;
        n = req & m_en & ~m_cls;
        chk(fiq == |f, {tag, " R4 fiq_o"}, DW'(fiq), DW'(|f));
        chk(irq == |n, {tag, " R5 irq_o"}, DW'(irq), DW'(|n));
        rd(8'h00, d); chk(d == DW'(req), {tag, " R2 raw"}, d, DW'(req));
        rd(8'h01, d); chk(d == DW'(f), {tag, " R4 fast status"}, d, DW'(f));
        rd(8'h02, d); chk(d == DW'(n), {tag, " R5 normal status"}, d, DW'(n));
        rd(8'h06, d); chk(d == exp_vec(req), {tag, " R6/R7 vector"}, d, exp_vec(req));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] d, v0;
        void'($urandom(32'd1234));
        m_en = '0; m_cls = '0; m_dflt = '0;
        for (int i = 0; i < NCH; i++) begin m_prio[i] = '0; m_vec[i] = '0; end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk(!fiq && !irq, "R1 outputs low", DW'({fiq, irq}), '0);
        rd(8'h03, d); chk(d == '0, "R1 enable", d, '0);
        rd(8'h05, d); chk(d == '0, "R1 class", d, '0);
        rd(8'h47, d); chk(d == '0, "R1 prio", d, '0);
        rd(8'h9f, d); chk(d == '0, "R1 vector", d, '0);
        rd(8'h07, d); chk(d == '0, "R1 default", d, '0);
        rd(8'h06, d); chk(d == '0, "R1 vector read", d, '0);

        // program vectors and default
        for (int i = 0; i < NCH; i++) begin
            m_vec[i] = $urandom;
            wr(8'h80 + 8'(i), m_vec[i]);
        end
        m_dflt = 32'hDEAD_0000;
        wr(8'h07, m_dflt);
        rd(8'h95, d); chk(d == m_vec[21], "R7 vector reg readback", d, m_vec[21]);

        // R6 tie and priority
        m_en = 32'h0000_0228; wr(8'h03, DW'(m_en));
        rd(8'h03, d); chk(d == DW'(m_en), "R3 enable readback", d, DW'(m_en));
        set_prio(3, 4'd7); set_prio(5, 4'd2); set_prio(9, 4'd2);
        @(negedge clk); req = 32'h0000_0228;
        settle(4);
        rd(8'h06, d); chk(d == m_vec[5], "R6 tie lowest channel", d, m_vec[5]);
        set_prio(9, 4'd1); settle(2);
        rd(8'h06, d); chk(d == m_vec[9], "R6 smaller value wins", d, m_vec[9]);

        // R9 fast channel excluded even at priority 0
        set_prio(5, 4'd0);
        m_cls = 32'h0000_0020; wr(8'h05, DW'(m_cls));
        settle(2);
        rd(8'h06, d); chk(d == m_vec[9], "R9 fast excluded", d, m_vec[9]);
        chk(fiq && irq, "R4 fiq with irq", DW'({fiq, irq}), 2'b11);

        // R3 enable clear removes channel on next cycle
        wr(8'h04, 32'h0000_0020);
        chk(!fiq, "R3 clear drops fiq next cycle", DW'(fiq), '0);
        wr(8'h04, 32'h0000_0208);
        chk(!irq, "R3 clear drops irq next cycle", DW'(irq), '0);
        m_en = '0;
        settle(2);
        rd(8'h06, d); chk(d == m_dflt, "R7 default vector", d, m_dflt);

        // R2 latency and R8 end of service
        req = '0; m_cls = '0; wr(8'h05, '0);
        m_en = 32'h0000_1000; wr(8'h03, DW'(m_en));
        settle(3);
        @(negedge clk); req[12] = 1'b1;
        @(negedge clk); chk(!irq, "R2 not yet after one edge", DW'(irq), '0);
        @(negedge clk); chk(irq, "R2 asserted after two edges", DW'(irq), 1);
        settle(2);
        rd(8'h06, v0);
        wr(8'h06, 32'hFFFF_FFFF);
        chk(irq, "R8 ack keeps irq", DW'(irq), 1);
        rd(8'h06, d); chk(d == v0, "R8 ack keeps vector", d, v0);
        rd(8'h03, d); chk(d == DW'(m_en), "R8 ack keeps enable", d, DW'(m_en));
        req[12] = 1'b0;
        @(negedge clk); chk(irq, "R2 release after one edge", DW'(irq), 1);
        @(negedge clk); chk(!irq, "R2 release after two edges", DW'(irq), '0);

        // random mix
        for (int it = 0; it < 60; it++) begin
            m_en = $urandom; m_cls = $urandom & $urandom;
            wr(8'h04, '1); wr(8'h03, DW'(m_en)); wr(8'h05, DW'(m_cls));
            for (int c = 0; c < 6; c++) begin
                int ch;
                ch = int'($urandom % NCH);
                set_prio(ch, (it % 2 == 0) ? 4'($urandom % 4) : 4'($urandom));
            end
            @(negedge clk); req = $urandom & $urandom;
            settle(4);
            full_check($sformatf("rand%0d", it));
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule